// File: doc/BRIEF.md
# Two-Cycle Port Access Unit

This unit carries out the port input and port output operations of a small 8-bit processor core. The core issues a request that names the direction (input or output) and an addressing form. In the direct form a 5-bit field of the instruction selects one of the low 32 ports. In the register-indirect form a full 8-bit register value selects any of the 256 ports. Each access takes two cycles on the external bus. The port number stays on the address bus for both cycles. The single-cycle read or write strobe comes only in the second cycle.

The unit asserts a stall output during the first cycle of an access, so the core holds its next instruction. During the second cycle the core may issue a new request, and that request begins on the following cycle with no idle gap. For an input access, the byte on the data-in bus is captured at the end of the strobe cycle. It is then returned to the core together with a one-cycle write-back enable for the destination register. Instruction decode and the register file are not part of this unit.

Top module: `iop_port_unit`

## Requirements
- R1: While reset is asserted and right after it, `stall`, `io_rd_stb`, `io_wr_stb` and `wb_en` are 0, and `io_addr` and `io_dout` are 0.
- R2: A direct request (`req_indirect`=0) drives `io_addr` with the 5-bit `req_imm` zero-extended to 8 bits, so only ports 0 to 31 are reachable. `req_reg` is ignored.
- R3: An indirect request (`req_indirect`=1) drives `io_addr` with the full 8-bit `req_reg`, so ports 0 to 255 are reachable. `req_imm` is ignored.
- R4: The port number appears on `io_addr` in the cycle after the request is accepted and stays unchanged in the cycle after that: two cycles in all.
- R5: `stall` is 1 in the first cycle of every access and 0 in the second.
- R6: For an input request (`req_write`=0), `io_rd_stb` is high for exactly the second cycle, and `io_wr_stb` stays low.
- R7: For an output request (`req_write`=1), `io_wr_stb` is high for exactly the second cycle, and `io_rd_stb` stays low. `io_dout` carries `req_wdata` in both cycles.
- R8: For an input access, the value on `io_din` in the strobe cycle appears on `wb_data` in the next cycle, with `wb_en` high for that one cycle only.
- R9: A request raised while `stall` is 1 is ignored. The access in progress keeps its address, its direction and its data.
- R10: A request raised in the second cycle of an access is accepted, and its first cycle follows at once.
- R11: With no access in progress, both strobes are low, and `io_addr` and `io_dout` return to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request an access in this cycle |
| req_write | input | 1 | 1 for port output, 0 for port input |
| req_indirect | input | 1 | 1 takes the port number from the register value |
| req_imm | input | 5 | Immediate port number for the direct form |
| req_reg | input | 8 | Register value used as the port number in the indirect form |
| req_wdata | input | 8 | Register data for an output access |
| io_din | input | 8 | External input data bus |
| io_addr | output | 8 | External port address bus |
| io_dout | output | 8 | External output data bus |
| io_rd_stb | output | 1 | Read strobe, second cycle of an input access |
| io_wr_stb | output | 1 | Write strobe, second cycle of an output access |
| stall | output | 1 | Holds the core during the first cycle of an access |
| wb_data | output | 8 | Byte captured from the input bus |
| wb_en | output | 1 | Write-back enable for the destination register |

## Verification
The embedded properties check, on every cycle, the timing skeleton of an access. Both strobes are never high together, and a strobe is never high in two consecutive cycles. Every strobe follows a stall cycle with the address unchanged. Every write-back pulse follows a read strobe and carries the byte that was on the input bus in that strobe cycle. Only the bench's scenarios can show that the correct port number was chosen from the immediate or from the register, with zero extension at the 31/32 boundary. The same holds for three more behaviours: requests during the stall are dropped, back-to-back accesses start without a gap, and the buses fall back to zero when idle.

// File: rtl/iop_pkg.sv
package iop_pkg;

  // Access phase: idle, address-only first cycle, strobe second cycle
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2
  } iop_phase_e;

endpackage

// File: rtl/iop_addr_sel.sv
module iop_addr_sel #(
  parameter int IMM_W  = 5,
  parameter int ADDR_W = 8
) (
  input  logic              indirect,
  input  logic [IMM_W-1:0]  imm,
  input  logic [ADDR_W-1:0] reg_val,
  output logic [ADDR_W-1:0] addr
);

  localparam int PAD_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] direct_addr;

  generate
    if (PAD_W > 0) begin : g_pad
      assign direct_addr = {{PAD_W{1'b0}}, imm};
    end else begin : g_nopad
      assign direct_addr = imm[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    if (indirect) addr = reg_val;
    else          addr = direct_addr;
  end

endmodule

// File: rtl/iop_seq.sv
module iop_seq
  import iop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       accept,
  output iop_phase_e phase
);

  iop_phase_e phase_q, phase_d;

  // A new request is taken whenever the core is not stalled
  assign accept = req_valid && (phase_q != PH_SETUP);
  assign phase  = phase_q;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_SETUP: phase_d = PH_STROBE;
      default:  phase_d = accept ? PH_SETUP : PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  AST_SETUP_THEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETUP) |=> (phase_q == PH_STROBE)); // R5

endmodule

// File: rtl/iop_bus_regs.sv
module iop_bus_regs
  import iop_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  iop_phase_e        phase,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              write_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] dout_q,
  output logic              write_q
);

  logic              load_en;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] dout_d;
  logic              write_d;

  assign load_en = accept || (phase == PH_STROBE);

  always_comb begin
    if (accept) begin
      addr_d  = addr_in;
      dout_d  = write_in ? wdata_in : '0;
      write_d = write_in;
    end else begin
      addr_d  = '0;
      dout_d  = '0;
      write_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      dout_q  <= '0;
      write_q <= 1'b0;
    end else if (load_en) begin
      addr_q  <= addr_d;
      dout_q  <= dout_d;
      write_q <= write_d;
    end
  end

  AST_HOLD_IN_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETUP) |=> ($stable(addr_q) && $stable(dout_q))); // R9

endmodule

// File: rtl/iop_rd_capture.sv
module iop_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] data_q,
  output logic              valid_q
);

  logic [DATA_W-1:0] data_d;

  assign data_d = cap_en ? din : data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= cap_en;
    end
  end

endmodule

// File: rtl/iop_port_unit.sv
module iop_port_unit
  import iop_pkg::*;
#(
  parameter int IMM_W  = 5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_indirect,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] io_din,
  output logic [ADDR_W-1:0] io_addr,
  output logic [DATA_W-1:0] io_dout,
  output logic              io_rd_stb,
  output logic              io_wr_stb,
  output logic              stall,
  output logic [DATA_W-1:0] wb_data,
  output logic              wb_en
);

  iop_phase_e        phase;
  logic              accept;
  logic [ADDR_W-1:0] sel_addr;
  logic              is_write;

  iop_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .accept    (accept),
    .phase     (phase)
  );

  iop_addr_sel #(.IMM_W(IMM_W), .ADDR_W(ADDR_W)) i_addr_sel (
    .indirect (req_indirect),
    .imm      (req_imm),
    .reg_val  (req_reg),
    .addr     (sel_addr)
  );

  iop_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bus_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .phase    (phase),
    .addr_in  (sel_addr),
    .wdata_in (req_wdata),
    .write_in (req_write),
    .addr_q   (io_addr),
    .dout_q   (io_dout),
    .write_q  (is_write)
  );

  assign stall     = (phase == PH_SETUP);
  assign io_rd_stb = (phase == PH_STROBE) && !is_write;
  assign io_wr_stb = (phase == PH_STROBE) &&  is_write;

  iop_rd_capture #(.DATA_W(DATA_W)) i_rd_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (io_rd_stb),
    .din     (io_din),
    .data_q  (wb_data),
    .valid_q (wb_en)
  );

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd_stb && io_wr_stb)); // R6

  AST_STROBE_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd_stb || io_wr_stb) |-> $past(stall)); // R5

  AST_ADDR_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd_stb || io_wr_stb) |-> $stable(io_addr)); // R4

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd_stb |=> !io_rd_stb); // R6

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr_stb |=> !io_wr_stb); // R7

  AST_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> ($past(io_rd_stb) && (wb_data == $past(io_din)))); // R8

endmodule

// File: tb/test_iop_port_unit.sv
`timescale 1ns/1ps
module test_iop_port_unit;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_write, req_indirect;
  logic [4:0] req_imm;
  logic [7:0] req_reg, req_wdata, io_din;
  logic [7:0] io_addr, io_dout, wb_data;
  logic       io_rd_stb, io_wr_stb, stall, wb_en;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  iop_port_unit i_iop_port_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_indirect(req_indirect), .req_imm(req_imm), .req_reg(req_reg),
    .req_wdata(req_wdata), .io_din(io_din), .io_addr(io_addr), .io_dout(io_dout),
    .io_rd_stb(io_rd_stb), .io_wr_stb(io_wr_stb), .stall(stall),
    .wb_data(wb_data), .wb_en(wb_en)
  );

  // {write, indirect, imm[4:0], reg[7:0], wdata[7:0], din[7:0], expected addr[7:0]}
  localparam int NV = 8;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 1'b0, 5'd0,  8'hFF, 8'h00, 8'h5A, 8'h00},  // direct read, port 0
    {1'b0, 1'b0, 5'd31, 8'h80, 8'h00, 8'hA5, 8'h1F},  // direct read, top direct port
    {1'b1, 1'b0, 5'd17, 8'hEE, 8'h3C, 8'h00, 8'h11},  // direct write
    {1'b0, 1'b1, 5'd3,  8'hFF, 8'h00, 8'hC3, 8'hFF},  // indirect read, port 255
    {1'b0, 1'b1, 5'd31, 8'h20, 8'h00, 8'h01, 8'h20},  // indirect read, port 32
    {1'b1, 1'b1, 5'd9,  8'h00, 8'hFF, 8'h00, 8'h00},  // indirect write, port 0
    {1'b1, 1'b1, 5'd0,  8'h9B, 8'h81, 8'h00, 8'h9B},  // indirect write, high port
    {1'b1, 1'b0, 5'd31, 8'h7F, 8'h42, 8'h00, 8'h1F}   // direct write, reg ignored
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive_req(input logic w, input logic ind, input logic [4:0] imm,
                           input logic [7:0] rg, input logic [7:0] wd);
    req_valid = 1'b1; req_write = w; req_indirect = ind;
    req_imm = imm; req_reg = rg; req_wdata = wd;
  endtask

  task automatic idle_req();
    req_valid = 1'b0; req_write = 1'b0; req_indirect = 1'b0;
    req_imm = '0; req_reg = '0; req_wdata = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 8'h01, 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; io_din = '0;
    idle_req();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 stall", {7'd0, stall}, 8'h00);
    chk("R1 strobes", {6'd0, io_rd_stb, io_wr_stb}, 8'h00);
    chk("R1 wb_en", {7'd0, wb_en}, 8'h00);
    chk("R1 addr", io_addr, 8'h00);
    chk("R1 dout", io_dout, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release stall", {7'd0, stall}, 8'h00);

    // Table-driven accesses: R2 R3 R4 R5 R6 R7 R8 R11
    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      drive_req(v[38], v[37], v[36:32], v[31:24], v[23:16]);
      @(negedge clk);                       // first cycle
      idle_req();
      io_din = v[15:8];
      chk(v[37] ? "R3 addr c1" : "R2 addr c1", io_addr, v[7:0]);
      chk("R5 stall c1", {7'd0, stall}, 8'h01);
      chk("R6 no strobe c1", {6'd0, io_rd_stb, io_wr_stb}, 8'h00);
      if (v[38]) chk("R7 dout c1", io_dout, v[23:16]);
      @(negedge clk);                       // second cycle
      chk("R4 addr c2", io_addr, v[7:0]);
      chk("R5 stall c2", {7'd0, stall}, 8'h00);
      if (v[38]) begin
        chk("R7 strobes c2", {6'd0, io_rd_stb, io_wr_stb}, 8'h01);
        chk("R7 dout c2", io_dout, v[23:16]);
      end else begin
        chk("R6 strobes c2", {6'd0, io_rd_stb, io_wr_stb}, 8'h02);
      end
      @(negedge clk);                       // after the access
      io_din = 8'hEE;
      chk("R11 idle strobes", {6'd0, io_rd_stb, io_wr_stb}, 8'h00);
      chk("R11 idle addr", io_addr, 8'h00);
      chk("R11 idle dout", io_dout, 8'h00);
      chk("R8 wb_en", {7'd0, wb_en}, {7'd0, ~v[38]});
      if (!v[38]) chk("R8 wb_data", wb_data, v[15:8]);
      @(negedge clk);
      chk("R8 wb_en single", {7'd0, wb_en}, 8'h00);
    end

    // R9: request during stall is ignored
    drive_req(1'b1, 1'b0, 5'd7, 8'h00, 8'h66);
    @(negedge clk);
    drive_req(1'b0, 1'b1, 5'd0, 8'hC8, 8'h00);
    @(negedge clk);
    idle_req();
    chk("R9 addr kept", io_addr, 8'h07);
    chk("R9 dout kept", io_dout, 8'h66);
    chk("R9 direction kept", {6'd0, io_rd_stb, io_wr_stb}, 8'h01);
    @(negedge clk);
    chk("R9 no second access", {7'd0, stall}, 8'h00);
    chk("R9 addr idle", io_addr, 8'h00);
    @(negedge clk);

    // R10: back-to-back read then write
    drive_req(1'b0, 1'b1, 5'd0, 8'hAB, 8'h00);
    @(negedge clk);
    idle_req();
    io_din = 8'h3D;
    @(negedge clk);
    drive_req(1'b1, 1'b0, 5'd4, 8'h00, 8'h99);
    chk("R10 read strobe", {7'd0, io_rd_stb}, 8'h01);
    @(negedge clk);
    idle_req();
    io_din = 8'h00;
    chk("R10 next addr", io_addr, 8'h04);
    chk("R10 next stall", {7'd0, stall}, 8'h01);
    chk("R10 next dout", io_dout, 8'h99);
    chk("R10 wb_en of read", {7'd0, wb_en}, 8'h01);
    chk("R10 wb_data of read", wb_data, 8'h3D);
    @(negedge clk);
    chk("R10 write strobe", {6'd0, io_rd_stb, io_wr_stb}, 8'h01);
    chk("R10 wb_en single", {7'd0, wb_en}, 8'h00);
    @(negedge clk);

    // R1: reset in the middle of an access
    drive_req(1'b1, 1'b1, 5'd0, 8'h55, 8'h77);
    @(negedge clk);
    idle_req();
    rst_n = 1'b0;
    #1;
    chk("R1 async stall", {7'd0, stall}, 8'h00);
    chk("R1 async addr", io_addr, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 no strobe after reset", {6'd0, io_rd_stb, io_wr_stb}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule